// File: doc/BRIEF.md
# Scatter-Gather Storage DMA Engine

This block is the bus-master data mover of a single storage channel. Software builds a chain of 16-byte descriptors in system memory, programs the chain's base address and a completion-area address through a small word-addressed register file, then writes a start command. The engine fetches each descriptor, moves the described buffer between a device-side data port and memory one 32-bit word at a time, and follows the chain until a descriptor carries the end-of-list flag.

When the final data word of the chain has been written or read, the engine fills a 128-byte completion area with all-ones words. Software polls that area rather than a status register, so that it never trusts a register read that could overtake data still in flight to memory. The engine keeps two byte counters, one for each side of the transfer, and both can be read back. A stop command halts the engine within one cycle. A memory error response also halts the engine and latches an error flag.

Top module: `dma_sg_engine`

## Requirements
- R1: A descriptor is four 32-bit words, each stored big-endian (most significant byte at the lowest address). Word 1 gives the buffer address. Word 3 gives the byte length in bits 15:0 and the end-of-list flag in bit 31. Words 0 and 2 and bits 30:16 of word 3 are ignored.
- R2: Registers are selected by word offset on `regAddr`: 0 timing, 1 list base low, 2 list base high, 3 current address (read-only), 4 current address high, 5 device byte count (read-only), 6 memory byte count (read-only), 7 control/status, 8 completion address. Unused offsets read as 0, and all registers reset to 0.
- R3: Control/status bits: start 0, stop 1, direction 2 (1 means device to memory), active 3, error 4. Writing start while idle sets active, clears both byte counters and the error flag, latches the direction and loads the descriptor pointer from the list base. Writing start while active has no effect.
- R4: Writing stop sets bit 1, which reads 1 until the halt has happened and then clears itself one cycle later. The halt clears active, makes no further memory or device handshakes and makes no completion write.
- R5: In the device-to-memory direction, each word accepted on the device input is written to the current address. The device count rises by 4 when the word is accepted, and the memory count and the current address rise by 4 when the write is acknowledged.
- R6: In the memory-to-device direction, each word read from the current address is presented on the device output in order. The memory count rises by 4 per read and the device count by 4 per device handshake.
- R7: A length field of 0 moves 65536 bytes (16384 words).
- R8: The descriptor pointer advances by 16 bytes after each descriptor that lacks end-of-list, and the chain continues with the next descriptor.
- R9: After the last data word of an end-of-list descriptor, the engine writes 32 words of 0xFFFFFFFF to the completion address plus 0, 4 and onward up to 124, and then clears active.
- R10: A memory error response during a descriptor fetch or a data beat sets the error bit and clears active. No write completes for that beat, and no completion write follows.
- R11: Lengths are counted in whole words. After a transfer the current address register holds the byte after the last data word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory response for the current request |
| memErr | input | 1 | Response carries an error (with memAck) |
| devInValid | input | 1 | Device has a word for memory |
| devInReady | output | 1 | Engine accepts a device word |
| devInData | input | 32 | Device word |
| devOutValid | output | 1 | Engine presents a word to the device |
| devOutReady | input | 1 | Device takes the word |
| devOutData | output | 32 | Word for the device |

## Verification
The assertions check on every cycle that the engine makes no memory request while it is idle, that a pending stop blocks every handshake and clears itself along with active, that an error response always leaves error set and active clear, and that a start written mid-transfer never changes the latched direction. Only the bench scenarios can show the data itself: byte-swapped descriptor decoding, address and order of every written word, chain following, the 65536-byte case for a zero length, the exact completion pattern, and the counter values after a normal end, a stop and an error.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int unsigned REG_TIMING  = 0;
  localparam int unsigned REG_LIST_LO = 1;
  localparam int unsigned REG_LIST_HI = 2;
  localparam int unsigned REG_CUR_LO  = 3;
  localparam int unsigned REG_CUR_HI  = 4;
  localparam int unsigned REG_DEV_CNT = 5;
  localparam int unsigned REG_MEM_CNT = 6;
  localparam int unsigned REG_CTRL    = 7;
  localparam int unsigned REG_COMPL   = 8;

  localparam int unsigned CTL_START = 0;
  localparam int unsigned CTL_STOP  = 1;
  localparam int unsigned CTL_DIR   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_COMPL} sgdState_e;
  typedef enum logic [1:0] {SEL_DESC, SEL_DATA, SEL_COMPL} memSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadList;  // start: load pointer, clear counters
    logic    setAddr;   // descriptor word 1 arrived
    logic    setLen;    // descriptor word 3 arrived
    logic    nextDesc;  // step descriptor pointer
    logic    capDev;    // capture device word into buffer
    logic    capMem;    // capture memory word into buffer
    logic    memBeat;   // data memory beat acknowledged
    logic    devBeat;   // device handshake
    logic    dataDone;  // one word finished on the far side
    memSel_e sel;
  } sgdStrobe_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
  import sgd_pkg::*;
#(
  parameter int unsigned COMPL_WORDS = 32,
  parameter int unsigned BEAT_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              wdStart,
  input  logic              wdStop,
  input  logic              wdDir,
  input  logic              memAck,
  input  logic              memErr,
  input  logic              lastWord,
  input  logic              descEol,
  input  logic              devInValid,
  input  logic              devOutReady,
  output logic              memReq,
  output logic              memWrite,
  output logic              devInReady,
  output logic              devOutValid,
  output sgdStrobe_t        strobe,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              active,
  output logic              stopPend,
  output logic              errFlag,
  output logic              dirFlag
);
  localparam logic [BEAT_W-1:0] BEAT_LAST  = BEAT_W'(COMPL_WORDS - 1);
  localparam logic [BEAT_W-1:0] FETCH_LAST = BEAT_W'(3);

  sgdState_e state;
  logic bufFull;
  logic run, inFetch, inXfer, inCompl;
  logic okAck, errAck, devInFire, devOutFire, startGo, dataDone;

  always_comb begin
    run         = active & ~stopPend;
    inFetch     = state == ST_FETCH;
    inXfer      = state == ST_XFER;
    inCompl     = state == ST_COMPL;
    memReq      = run & (inFetch | inCompl | (inXfer & (dirFlag ? bufFull : ~bufFull)));
    memWrite    = inCompl | (inXfer & dirFlag);
    devInReady  = run & inXfer & dirFlag & ~bufFull;
    devOutValid = run & inXfer & ~dirFlag & bufFull;
    okAck       = memReq & memAck & ~memErr;
    errAck      = memReq & memAck & memErr;
    devInFire   = devInValid & devInReady;
    devOutFire  = devOutValid & devOutReady;
    startGo     = ctrlWr & wdStart & ~wdStop & ~active & ~stopPend;
    dataDone    = inXfer & (dirFlag ? okAck : devOutFire);

    strobe.loadList = startGo;
    strobe.setAddr  = okAck & inFetch & (beatIdx == BEAT_W'(1));
    strobe.setLen   = okAck & inFetch & (beatIdx == FETCH_LAST);
    strobe.nextDesc = dataDone & lastWord & ~descEol;
    strobe.capDev   = devInFire;
    strobe.capMem   = okAck & inXfer & ~dirFlag;
    strobe.memBeat  = okAck & inXfer;
    strobe.devBeat  = devInFire | devOutFire;
    strobe.dataDone = dataDone;
    strobe.sel      = inFetch ? SEL_DESC : (inCompl ? SEL_COMPL : SEL_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bufFull  <= 1'b0;
      beatIdx  <= '0;
      active   <= 1'b0;
      stopPend <= 1'b0;
      errFlag  <= 1'b0;
      dirFlag  <= 1'b0;
    end else if (stopPend) begin
      stopPend <= ctrlWr & wdStop;
      active   <= 1'b0;
      state    <= ST_IDLE;
      bufFull  <= 1'b0;
      beatIdx  <= '0;
    end else begin
      if (ctrlWr && wdStop) stopPend <= 1'b1;
      if (startGo) begin
        active  <= 1'b1;
        errFlag <= 1'b0;
        dirFlag <= wdDir;
        state   <= ST_FETCH;
        beatIdx <= '0;
        bufFull <= 1'b0;
      end else if (errAck) begin
        errFlag <= 1'b1;
        active  <= 1'b0;
        state   <= ST_IDLE;
        bufFull <= 1'b0;
        beatIdx <= '0;
      end else begin
        unique case (state)
          ST_FETCH: if (okAck) begin
            if (beatIdx == FETCH_LAST) begin
              beatIdx <= '0;
              state   <= ST_XFER;
              bufFull <= 1'b0;
            end else beatIdx <= beatIdx + 1'b1;
          end
          ST_XFER: begin
            if (devInFire || strobe.capMem) bufFull <= 1'b1;
            else if (dataDone) bufFull <= 1'b0;
            if (dataDone && lastWord) begin
              state   <= descEol ? ST_COMPL : ST_FETCH;
              beatIdx <= '0;
            end
          end
          ST_COMPL: if (okAck) begin
            if (beatIdx == BEAT_LAST) begin
              state   <= ST_IDLE;
              active  <= 1'b0;
              beatIdx <= '0;
            end else beatIdx <= beatIdx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgd_datapath.sv
module sgd_datapath
  import sgd_pkg::*;
#(
  parameter int unsigned BEAT_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  sgdStrobe_t        strobe,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic [31:0]       memRdata,
  input  logic [31:0]       devInData,
  input  logic              active,
  input  logic              stopPend,
  input  logic              errFlag,
  input  logic              dirFlag,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       devOutData,
  output logic              lastWord,
  output logic              descEol
);
  localparam int unsigned REM_W = 17;

  logic [31:0] timingReg, listLo, listHi, curHi, complAddr, curAddr, descPtr, bufWord;
  logic [CNT_W-1:0] devCnt, memCnt;
  logic [REM_W-1:0] remain;
  logic [31:0] descWord;

  assign descWord = swapBytes(memRdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timingReg <= '0; listLo <= '0; listHi <= '0; curHi <= '0; complAddr <= '0;
      curAddr <= '0; descPtr <= '0; bufWord <= '0; devCnt <= '0; memCnt <= '0;
      remain <= '0; descEol <= 1'b0;
    end else begin
      if (regWe) begin
        unique case (regAddr)
          4'(REG_TIMING):  timingReg <= regWdata;
          4'(REG_LIST_LO): listLo    <= regWdata;
          4'(REG_LIST_HI): listHi    <= regWdata;
          4'(REG_CUR_HI):  curHi     <= regWdata;
          4'(REG_COMPL):   complAddr <= regWdata;
          default: ;
        endcase
      end
      if (strobe.loadList) begin
        descPtr <= listLo;
        devCnt  <= '0;
        memCnt  <= '0;
      end else begin
        if (strobe.nextDesc) descPtr <= descPtr + 32'd16;
        if (strobe.devBeat)  devCnt  <= devCnt + CNT_W'(4);
        if (strobe.memBeat)  memCnt  <= memCnt + CNT_W'(4);
      end
      if (strobe.setAddr) curAddr <= descWord;
      else if (strobe.memBeat) curAddr <= curAddr + 32'd4;
      if (strobe.setLen) begin
        descEol <= descWord[31];
        remain  <= (descWord[15:0] == 16'd0) ? REM_W'(17'h10000) : {1'b0, descWord[15:0]};
      end else if (strobe.dataDone) begin
        remain <= (remain > REM_W'(4)) ? remain - REM_W'(4) : '0;
      end
      if (strobe.capDev) bufWord <= devInData;
      else if (strobe.capMem) bufWord <= memRdata;
    end
  end

  assign lastWord   = remain <= REM_W'(4);
  assign devOutData = bufWord;
  assign memWdata   = (strobe.sel == SEL_COMPL) ? '1 : bufWord;

  always_comb begin
    unique case (strobe.sel)
      SEL_DESC:  memAddr = descPtr + {28'd0, beatIdx[1:0], 2'b00};
      SEL_COMPL: memAddr = complAddr + {{(30 - BEAT_W){1'b0}}, beatIdx, 2'b00};
      default:   memAddr = curAddr;
    endcase
  end

  always_comb begin
    unique case (regAddr)
      4'(REG_TIMING):  regRdata = timingReg;
      4'(REG_LIST_LO): regRdata = listLo;
      4'(REG_LIST_HI): regRdata = listHi;
      4'(REG_CUR_LO):  regRdata = curAddr;
      4'(REG_CUR_HI):  regRdata = curHi;
      4'(REG_DEV_CNT): regRdata = 32'(devCnt);
      4'(REG_MEM_CNT): regRdata = 32'(memCnt);
      4'(REG_CTRL):    regRdata = {27'd0, errFlag, active, dirFlag, stopPend, 1'b0};
      4'(REG_COMPL):   regRdata = complAddr;
      default:         regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_sg_engine.sv
module dma_sg_engine
  import sgd_pkg::*;
#(
  parameter int unsigned COMPL_BYTES = 128,
  parameter int unsigned CNT_W       = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        devInValid,
  output logic        devInReady,
  input  logic [31:0] devInData,
  output logic        devOutValid,
  input  logic        devOutReady,
  output logic [31:0] devOutData
);
  localparam int unsigned COMPL_WORDS = COMPL_BYTES / 4;
  localparam int unsigned BEAT_W      = $clog2(COMPL_WORDS);

  sgdStrobe_t        strobe;
  logic [BEAT_W-1:0] beatIdx;
  logic ctrlWr, active, stopPend, errFlag, dirFlag, lastWord, descEol;

  assign ctrlWr = regWe && (regAddr == 4'(REG_CTRL));

  sgd_ctrl #(.COMPL_WORDS(COMPL_WORDS), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr),
    .wdStart(regWdata[CTL_START]), .wdStop(regWdata[CTL_STOP]), .wdDir(regWdata[CTL_DIR]),
    .memAck(memAck), .memErr(memErr), .lastWord(lastWord), .descEol(descEol),
    .devInValid(devInValid), .devOutReady(devOutReady),
    .memReq(memReq), .memWrite(memWrite), .devInReady(devInReady), .devOutValid(devOutValid),
    .strobe(strobe), .beatIdx(beatIdx), .active(active), .stopPend(stopPend),
    .errFlag(errFlag), .dirFlag(dirFlag)
  );

  sgd_datapath #(.BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strobe(strobe), .beatIdx(beatIdx), .memRdata(memRdata),
    .devInData(devInData), .active(active), .stopPend(stopPend), .errFlag(errFlag),
    .dirFlag(dirFlag), .memAddr(memAddr), .memWdata(memWdata), .devOutData(devOutData),
    .lastWord(lastWord), .descEol(descEol)
  );
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker (
  input logic clk,
  input logic rstN,
  input logic memReq,
  input logic memAck,
  input logic memErr,
  input logic devInReady,
  input logic devOutValid,
  input logic ctrlWr,
  input logic wdStart,
  input logic wdStop,
  input logic active,
  input logic stopPend,
  input logic errFlag,
  input logic dirFlag
);
  // R9: no memory traffic outside an active transfer
  a_r9_req_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> active);

  // R4: a pending stop blocks every handshake
  a_r4_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stopPend |-> (!memReq && !devInReady && !devOutValid));

  // R4: the stop bit clears itself with active one cycle later
  a_r4_stop_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (stopPend && !(ctrlWr && wdStop)) |=> (!stopPend && !active));

  // R10: error response halts and flags
  a_r10_error_halts: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> (errFlag && !active));

  // R3: start written while active keeps the latched direction
  a_r3_start_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (active && ctrlWr && wdStart) |=> (dirFlag == $past(dirFlag)));

  // R5: only one device side is in use at a time
  a_r5_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(devInReady && devOutValid));
endmodule

bind dma_sg_engine sgd_checker u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memErr(memErr),
  .devInReady(devInReady), .devOutValid(devOutValid), .ctrlWr(ctrlWr),
  .wdStart(regWdata[0]), .wdStop(regWdata[1]), .active(active),
  .stopPend(stopPend), .errFlag(errFlag), .dirFlag(dirFlag)
);

// File: tb/tb_dma_sg_engine.sv
`timescale 1ns/1ps
module tb_dma_sg_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWrite, memAck, memErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic devInValid, devInReady, devOutValid, devOutReady;
  logic [31:0] devInData, devOutData;

  always #2.5 clk = ~clk;

  dma_sg_engine dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .devInValid(devInValid), .devInReady(devInReady), .devInData(devInData),
    .devOutValid(devOutValid), .devOutReady(devOutReady), .devOutData(devOutData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int devSeq = 0;
  int expSeq = 0;
  int complHits = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:1023];
  logic [63:0] wrQ[$];
  logic [31:0] devQ[$];
  logic errEn = 1'b0;
  logic [31:0] errAddr = '0;

  assign memRdata    = mem[memAddr[11:2]];
  assign memAck      = memReq && ((cyc % 3) != 1);
  assign memErr      = memAck && errEn && (memAddr == errAddr);
  assign devInValid  = (cyc % 5) != 2;
  assign devInData   = 32'hA500_0000 + 32'(devSeq);
  assign devOutReady = (cyc % 4) != 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (devInValid && devInReady) devSeq <= devSeq + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] be(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memReq && memAck && memWrite && !memErr) begin
      if (memWdata == 32'hFFFF_FFFF && memAddr[31:28] == 4'h5) complHits++;
      if (wrQ.size() == 0) chk(1'b0, "R5/R9 unexpected memory write", {memAddr, memWdata}, 64'd0);
      else begin
        logic [63:0] e;
        e = wrQ.pop_front();
        chk({memAddr, memWdata} == e, "R5/R9 memory write", {memAddr, memWdata}, e);
      end
    end
    if (rstN && devOutValid && devOutReady) begin
      if (devQ.size() == 0) chk(1'b0, "R6 unexpected device word", {32'd0, devOutData}, 64'd0);
      else begin
        logic [31:0] d;
        d = devQ.pop_front();
        chk(devOutData == d, "R6 device word", {32'd0, devOutData}, {32'd0, d});
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdata;
  endtask

  task automatic putDesc(input int idx, input logic [31:0] addr, input logic [31:0] lenWord);
    mem[idx]     = be(32'hDEAD_0001);
    mem[idx + 1] = be(addr);
    mem[idx + 2] = be(32'hDEAD_0002);
    mem[idx + 3] = be(lenWord);
  endtask

  task automatic pushData(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      wrQ.push_back({base + 32'(4 * i), 32'hA500_0000 + 32'(expSeq)});
      expSeq++;
    end
  endtask

  task automatic pushCompl(input logic [31:0] base);
    for (int i = 0; i < 32; i++) wrQ.push_back({base + 32'(4 * i), 32'hFFFF_FFFF});
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int k = 0; k < 100000; k++) begin
      regRead(4'd7, v);
      if (!v[3]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int popped, hits0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state R2
    regRead(4'd7, v);  chk(v == 0, "R2 reset ctrl", {32'd0, v}, 0);
    regRead(4'd5, v);  chk(v == 0, "R2 reset dev count", {32'd0, v}, 0);
    regRead(4'd8, v);  chk(v == 0, "R2 reset completion addr", {32'd0, v}, 0);
    regWrite(4'd0, 32'h1234_5678);
    regRead(4'd0, v);  chk(v == 32'h1234_5678, "R2 timing readback", {32'd0, v}, {32'd0, 32'h1234_5678});
    regWrite(4'd5, 32'h0000_0040);
    regRead(4'd5, v);  chk(v == 0, "R2 dev count read-only", {32'd0, v}, 0);
    regRead(4'd12, v); chk(v == 0, "R2 unused offset", {32'd0, v}, 0);

    // chain, device to memory: R1 R5 R8 R9 R11 R3
    putDesc(0, 32'h3000_0000, 32'h7ABC_000C);
    putDesc(4, 32'h3000_FFF8, 32'h8000_0008);
    regWrite(4'd1, 32'h1000_0000);
    regWrite(4'd8, 32'h5000_0000);
    pushData(32'h3000_0000, 3);
    pushData(32'h3000_FFF8, 2);
    pushCompl(32'h5000_0000);
    regWrite(4'd7, 32'h0000_0005);
    regWrite(4'd7, 32'h0000_0001);
    regRead(4'd7, v);
    chk(v[4:2] == 3'b011, "R3 start while active ignored", {32'd0, v}, 64'h0C);
    waitIdle();
    chk(wrQ.size() == 0, "R9 chain writes all seen", wrQ.size(), 0);
    regRead(4'd5, v);  chk(v == 20, "R5 device count", {32'd0, v}, 20);
    regRead(4'd6, v);  chk(v == 20, "R5 memory count", {32'd0, v}, 20);
    regRead(4'd3, v);  chk(v == 32'h3001_0000, "R11 current address", {32'd0, v}, {32'd0, 32'h3001_0000});
    regRead(4'd7, v);  chk(v == 32'h04, "R9 idle after completion", {32'd0, v}, 64'h04);

    // memory to device: R6
    putDesc(16, 32'h2000_0400, 32'h8000_0010);
    for (int i = 0; i < 4; i++) begin
      mem[256 + i] = 32'hC0DE_0000 + 32'(i);
      devQ.push_back(32'hC0DE_0000 + 32'(i));
    end
    regWrite(4'd1, 32'h1000_0040);
    regWrite(4'd8, 32'h5000_0100);
    pushCompl(32'h5000_0100);
    regWrite(4'd7, 32'h0000_0001);
    waitIdle();
    chk(devQ.size() == 0, "R6 all device words seen", devQ.size(), 0);
    chk(wrQ.size() == 0, "R9 completion after read path", wrQ.size(), 0);
    regRead(4'd6, v);  chk(v == 16, "R6 memory count", {32'd0, v}, 16);
    regRead(4'd5, v);  chk(v == 16, "R6 device count", {32'd0, v}, 16);

    // zero length means 65536 bytes: R7
    putDesc(32, 32'h4000_0000, 32'h8000_0000);
    regWrite(4'd1, 32'h1000_0080);
    regWrite(4'd8, 32'h5000_0200);
    pushData(32'h4000_0000, 16384);
    pushCompl(32'h5000_0200);
    regWrite(4'd7, 32'h0000_0005);
    waitIdle();
    chk(wrQ.size() == 0, "R7 all 16384 words written", wrQ.size(), 0);
    regRead(4'd6, v);  chk(v == 32'h1_0000, "R7 memory count", {32'd0, v}, 64'h10000);
    regRead(4'd5, v);  chk(v == 32'h1_0000, "R7 device count", {32'd0, v}, 64'h10000);

    // stop: R4
    putDesc(48, 32'h6000_0000, 32'h8000_0100);
    regWrite(4'd1, 32'h1000_00C0);
    regWrite(4'd8, 32'h5000_0300);
    pushData(32'h6000_0000, 64);
    hits0 = complHits;
    regWrite(4'd7, 32'h0000_0005);
    repeat (20) @(negedge clk);
    regWrite(4'd7, 32'h0000_0002);
    #0.5 regAddr = 4'd7;
    #0.5 v = regRdata;
    chk(v[1] == 1'b1, "R4 stop reads 1 while pending", {32'd0, v}, 64'h02);
    regRead(4'd7, v);
    chk(v[3:1] == 3'b010, "R4 stop self-cleared and halted", {32'd0, v}, 64'h04);
    repeat (6) begin
      @(negedge clk);
      chk(!memReq && !devInReady, "R4 quiet after stop", {62'd0, memReq, devInReady}, 0);
    end
    popped = 64 - wrQ.size();
    wrQ.delete();
    regRead(4'd6, v);
    chk(v == 32'(popped * 4), "R4 memory count after stop", {32'd0, v}, 64'(popped * 4));
    regRead(4'd5, v2);
    chk(v2 - v == 0 || v2 - v == 4, "R4 device count after stop", {32'd0, v2}, {32'd0, v});
    chk(complHits == hits0, "R4 no completion write on stop", complHits, hits0);
    expSeq = devSeq;

    // memory error on data beat: R10
    putDesc(52, 32'h7000_0000, 32'h8000_0010);
    regWrite(4'd1, 32'h1000_00D0);
    errAddr = 32'h7000_0004; errEn = 1'b1;
    pushData(32'h7000_0000, 1);
    regWrite(4'd7, 32'h0000_0005);
    waitIdle();
    regRead(4'd7, v);
    chk(v[4:3] == 2'b10, "R10 error set, active clear", {32'd0, v}, 64'h14);
    regRead(4'd6, v);  chk(v == 4, "R10 memory count at error", {32'd0, v}, 4);
    chk(wrQ.size() == 0 && complHits == hits0, "R10 no completion write", complHits, hits0);
    expSeq = devSeq;

    // memory error on descriptor fetch: R10
    putDesc(56, 32'h7100_0000, 32'h8000_0010);
    regWrite(4'd1, 32'h1000_00E0);
    errAddr = 32'h1000_00EC;
    regWrite(4'd7, 32'h0000_0005);
    waitIdle();
    regRead(4'd7, v);
    chk(v[4:3] == 2'b10, "R10 fetch error", {32'd0, v}, 64'h14);
    regRead(4'd6, v);  chk(v == 0, "R10 no data after fetch error", {32'd0, v}, 0);
    errEn = 1'b0;
    expSeq = devSeq;

    // restart clears error: R3
    putDesc(60, 32'h3000_0100, 32'h8000_0004);
    regWrite(4'd1, 32'h1000_00F0);
    regWrite(4'd8, 32'h5000_0400);
    pushData(32'h3000_0100, 1);
    pushCompl(32'h5000_0400);
    regWrite(4'd7, 32'h0000_0005);
    regRead(4'd7, v);
    chk(v[4] == 1'b0 && v[3] == 1'b1, "R3 start clears error", {32'd0, v}, 64'h0C);
    waitIdle();
    chk(wrQ.size() == 0, "R9 completion after restart", wrQ.size(), 0);
    regRead(4'd6, v);  chk(v == 4, "R3 counters restarted", {32'd0, v}, 4);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule